// File: doc/BRIEF.md
# Burst-Four Double-Rate SRAM With Split Data Buses

This block is a synthesizable memory with a write-data bus and a read-data bus that are kept apart. Data moves on both halves of the interface clock, and every access moves a burst of four words. The interface clock is modelled by an internal clock `clk2x` running at twice its rate. A phase bit inside the block marks which `clk2x` edges stand for rising interface edges and which stand for falling ones. The block reports this phase on `rise_ph`, so a host can line its command up with a rising edge.

A command is sampled only on a rising-edge half, and only when both select inputs are high and no earlier burst still has beats left to move. The external address names an aligned group of four words. The block makes the two low index bits itself and counts them 0, 1, 2, 3 across the burst.

Write words are taken on the four `clk2x` edges that follow acceptance. For a read, each word is first held in an output pipeline register during the access. It is then released on the next rising half and the falling half after it. The data-valid flag and the echo clock run alongside the read data. A read placed straight after a write to the same group returns the data just written.

Top module: `ddr_burst4_sram`

## Requirements
- R1: A command (`go` high) is accepted only at a `clk2x` edge where `rise_ph` is 1. `go` at an edge where `rise_ph` is 0 starts nothing and writes nothing.
- R2: A command is accepted only when `sel_a` and `sel_b` are both 1. If either is 0, the command has no effect on memory or outputs.
- R3: A burst to external address A touches word indices 4*A+0, 4*A+1, 4*A+2 and 4*A+3, in that order. The two low index bits start at 0 and step by 1 for each beat.
- R4: For a write accepted at edge P0, `din` is stored as word k at edge P(1+k), for k = 0..3.
- R5: For a read accepted at edge P0, `dout` carries word k in the cycle after edge P(2+k). `dout_vld` is 1 in exactly those four cycles, and is 0 in the cycle after P1 and in the cycle after P6.
- R6: A read accepted at the rising edge where the last word of a write to the same address is taken (P4 of that write) returns all four newly written words.
- R7: While a burst has beats left before its last one, a new command is ignored. A command at the edge of the last beat (P4) is accepted.
- R8: `echo_clk` changes value every `clk2x` cycle. It is 1 while the beat launched by a rising edge is on `dout`, so it is 1 for read words 0 and 2 and 0 for words 1 and 3.
- R9: In the first cycle after reset is released, `rise_ph` is 1 and `dout`, `dout_vld` and `echo_clk` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Internal clock at twice the interface rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| rise_ph | output | 1 | 1 when the next `clk2x` edge is a rising interface edge |
| sel_a | input | 1 | First select, must be 1 to accept a command |
| sel_b | input | 1 | Second select, must be 1 to accept a command |
| go | input | 1 | Command request |
| wr | input | 1 | 1 = write burst, 0 = read burst |
| addr | input | AW | Group address of four words |
| din | input | DW | Write data, one word per `clk2x` edge |
| dout | output | DW | Read data, one word per `clk2x` cycle |
| dout_vld | output | 1 | 1 while `dout` holds a read word |
| echo_clk | output | 1 | Echo clock aligned with the `dout` beats |

## Verification
The bench builds the block with AW = 3 and DW = 8. This gives 32 words in 8 groups, so every group can be written and read back twice, once in isolated bursts and once with each read chained directly behind its write. Because the array is so small, the tests for commands that must be ignored cover every path that could corrupt a word. These are a command on a falling half, a command with one select low, and a command inside a running burst. Each of these tests reads back the group the command targeted and compares all four words.

// File: rtl/ddr_burst4_sram.sv
module ddr_burst4_sram #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          clk2x,
  input  logic          rst_n,
  output logic          rise_ph,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          echo_clk
);
  localparam int IW    = AW + 2;
  localparam int WORDS = 1 << IW;

  logic          ph, act, op_wr, fv, dv, eq;
  logic [1:0]    beat;
  logic [AW-1:0] base;
  logic [DW-1:0] fq, dq;
  logic [DW-1:0] mem [WORDS];

  wire          free = !act || beat == 2'd3;
  wire          take = rise_ph && go && sel_a && sel_b && free;
  wire [IW-1:0] idx  = {base, beat};

  assign rise_ph  = ~ph;
  assign dout     = dq;
  assign dout_vld = dv;
  assign echo_clk = eq;

  always_ff @(posedge clk2x)
    if (act && op_wr) mem[idx] <= din;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      eq    <= 1'b0;
      act   <= 1'b0;
      op_wr <= 1'b0;
      beat  <= 2'd0;
      base  <= '0;
      fv    <= 1'b0;
      dv    <= 1'b0;
      fq    <= '0;
      dq    <= '0;
    end else begin
      ph <= ~ph;
      eq <= ~ph;
      fv <= act && !op_wr;
      if (act && !op_wr) fq <= mem[idx];
      dq <= fq;
      dv <= fv;
      if (take) begin
        act   <= 1'b1;
        beat  <= 2'd0;
        base  <= addr;
        op_wr <= wr;
      end else if (act) begin
        beat <= beat + 2'd1;
        if (beat == 2'd3) act <= 1'b0;
      end
    end
  end

  AST_ECHO_TOGGLE: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) |-> echo_clk != $past(echo_clk)); // R8
  AST_FIRST_BEAT_HIGH: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(dout_vld) |-> echo_clk); // R8
  AST_FOUR_BEATS: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(dout_vld) |=> dout_vld ##1 dout_vld ##1 dout_vld); // R5
  AST_ACCEPT_GATED: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(act) |-> $past(sel_a && sel_b && go && rise_ph)); // R2
  AST_BURST_HOLD: assert property (@(posedge clk2x) disable iff (!rst_n)
    (act && beat != 2'd3) |=> $stable(base) && $stable(op_wr) && beat == $past(beat) + 2'd1); // R7
endmodule

// File: tb/sim_ddr_burst4_sram.sv
module sim_ddr_burst4_sram;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NA = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_a = 1'b1, sel_b = 1'b1, go = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic rise_ph, dout_vld, echo_clk;
  logic [DW-1:0] dout;
  logic [DW-1:0] exp_mem [4*NA];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ddr_burst4_sram #(.AW(AW), .DW(DW)) u0 (
    .clk2x(clk), .rst_n(rst_n), .rise_ph(rise_ph), .sel_a(sel_a), .sel_b(sel_b),
    .go(go), .wr(wr), .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld),
    .echo_clk(echo_clk));

  function automatic logic [DW-1:0] pat(int a, int k, int seed);
    return DW'((a * 37 + k * 11 + seed * 53 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] actual, logic [31:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic issue(logic w, int a, logic sa, logic sb);
    @(negedge clk);
    while (!rise_ph) @(negedge clk);
    go = 1'b1; wr = w; addr = AW'(a); sel_a = sa; sel_b = sb;
    @(negedge clk);
    go = 1'b0; sel_a = 1'b1; sel_b = 1'b1;
  endtask

  task automatic write_burst(int a, int seed, logic sa, logic sb, logic chain);
    issue(1'b1, a, sa, sb);
    for (int k = 0; k < 4; k++) begin
      din = pat(a, k, seed);
      if (k == 3 && chain) begin go = 1'b1; wr = 1'b0; addr = AW'(a); end
      @(negedge clk);
    end
    go = 1'b0;
    if (sa && sb)
      for (int k = 0; k < 4; k++) exp_mem[4*a+k] = pat(a, k, seed);
  endtask

  task automatic read_expect(int a, logic intrude, int b, string req);
    @(negedge clk);
    chk("R5 idle before data", dout_vld, 0);
    if (intrude) begin go = 1'b1; wr = 1'b1; addr = AW'(b); din = 8'hA5; end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) go = 1'b0;
      chk(req, dout, exp_mem[4*a+k]);
      chk("R5 valid", dout_vld, 1);
      chk("R8 echo", echo_clk, (k % 2 == 0) ? 1 : 0);
    end
    @(negedge clk);
    chk("R5 valid ends", dout_vld, 0);
  endtask

  task automatic read_burst(int a, string req);
    issue(1'b0, a, 1'b1, 1'b1);
    read_expect(a, 1'b0, 0, req);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 rise_ph", rise_ph, 1);
    chk("R9 dout", dout, 0);
    chk("R9 dout_vld", dout_vld, 0);
    chk("R9 echo_clk", echo_clk, 0);

    for (int a = 0; a < NA; a++) write_burst(a, 1, 1'b1, 1'b1, 1'b0);
    for (int a = 0; a < NA; a++) read_burst(a, "R3 R4 sweep read");

    for (int a = 0; a < NA; a++) begin
      write_burst(a, 2, 1'b1, 1'b1, 1'b1);
      read_expect(a, 1'b0, 0, "R6 chained read");
    end

    write_burst(2, 7, 1'b0, 1'b1, 1'b0);
    read_burst(2, "R2 sel_a low ignored");
    write_burst(5, 8, 1'b1, 1'b0, 1'b0);
    read_burst(5, "R2 sel_b low ignored");

    @(negedge clk);
    while (rise_ph) @(negedge clk);
    go = 1'b1; wr = 1'b1; addr = AW'(4); din = 8'h3C;
    @(negedge clk);
    go = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 falling-half command ignored", dout_vld, 0);
    end
    read_burst(4, "R1 falling-half write ignored");

    issue(1'b0, 1, 1'b1, 1'b1);
    read_expect(1, 1'b1, 6, "R7 read during intrusion");
    read_burst(6, "R7 mid-burst write ignored");

    write_burst(3, 9, 1'b1, 1'b1, 1'b0);
    issue(1'b0, 3, 1'b1, 1'b1);
    read_expect(3, 1'b0, 0, "R3 rewrite readback");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule